// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block collects sixteen raw interrupt sources and steers each one onto one of eight CPU interrupt lines under register control. Every source first passes through a two-flop synchronizer and a sense stage. The sense stage can invert the input so that it is active-low, and it can treat the input as level-sensitive or edge-sensitive. The result is one pending bit per source. Edge-mode pending bits are latched and stay set until software clears them.

Software sets up each source through a 4-bit routing nibble, which holds a target line number and an enable. For each CPU line it can read a 16-bit status half-word that lists the pending, enabled sources routed to that line. Each line also has its own output enable. A line output is the registered OR of its status bits, gated by that line's enable.

The register bus is 32 bits wide. It is addressed by word index, each write takes effect at the clock edge where `bus_wr` is high, and read data is registered, so it appears one clock after the address.

Top module: `irq_router`

## Requirements
- R1: After a synchronous active-high reset, every line output is 0 and the routing words (index 0 and 1), the output-enable word (index 6) and the sense word (index 8) all read back 0.
- R2: Source n is controlled by nibble n%8 of routing word n/8 (index 0 holds sources 0 to 7, index 1 holds sources 8 to 15). Bits 2:0 of the nibble give the target line and bit 3 enables the source. A disabled source never shows in any status half-word or line output, but its pending bit is kept, so setting the enable later makes it visible.
- R3: The status half-word for line k is in word index 2+k/2: bits 15:0 for even k and bits 31:16 for odd k. Bit n of that half-word is set when source n is pending, enabled and routed to line k.
- R4: A write to word index 7 clears the edge-latched pending bit of every source n whose data bit n is 1. Data bits that are 0 leave their pending bits unchanged. This word reads as 0.
- R5: Bit 16+k of word index 6 is the output enable of line k. Line k is driven high only when this bit is set and its status half-word is nonzero. The line is registered, so it follows one clock after the status changes.
- R6: Word index 8 holds two bits per source. Bit 2n set makes source n active-low (clear means active-high). Bit 2n+1 set makes source n level-sensitive (clear means edge-sensitive). The word reads back as written.
- R7: An edge-sensitive source becomes pending on an inactive-to-active transition of its qualified input, and it stays pending after the input returns inactive until it is cleared. Changing the polarity alone does not create a pending event.
- R8: A level-sensitive source is pending exactly while its qualified input is active, and a clear write has no lasting effect on it.
- R9: When a source is routed, enabled and its line is enabled, a change on the source input reaches the line output on the fourth rising clock edge after the input changes (two synchronizer stages, the pending register, the line register), and not earlier.
- R10: Writing zero to both routing words removes every source from every status half-word and drives every line output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word index |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's `bus_addr` |
| src_i | input | 16 | Raw interrupt source inputs, asynchronous |
| irq_line_o | output | 8 | Registered CPU interrupt line outputs |

## Verification
The routing path is driven with several source patterns, and each one separates a different failure:
- An active-high edge source is routed to an odd line. This checks both the nibble decode and the upper status half-word.
- A source is left disabled and then enabled. This shows that the enable masks the pending bit but does not drop it.
- An active-low level source and an active-high level source are used to check that polarity and trigger mode are decoded independently.
- An active-low edge source is driven with a rising transition that must be ignored and then a falling transition that must latch.

Clear writes that contain zeros at the pending position, and writes that turn off a line enable, show that a pending bit is kept separate from the line that drives it. Counting edges on both the rising and the falling change of a source pins down the four-register latency.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int BUS_W    = 32;
  localparam int NIB_W    = 4;
  localparam int HALF_W   = 16;
  localparam int DEF_SRC  = 16;
  localparam int DEF_LINE = 8;
  localparam int DEF_AW   = 4;
endpackage

// File: rtl/irq_src_sense.sv
module irq_src_sense (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic act_low_i,
  input  logic level_i,
  input  logic clr_i,
  output logic pend_o
);
  logic s1_q, s2_q, s2_d_q, pend_q;
  logic qual, qual_prev, hit;

  // qualification uses the current polarity on both samples, so a polarity
  // change alone never looks like an edge
  assign qual      = s2_q ^ act_low_i;
  assign qual_prev = s2_d_q ^ act_low_i;
  assign hit       = qual & ~qual_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s2_d_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      s2_d_q <= s2_q;
      if (level_i)    pend_q <= qual;
      else if (hit)   pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R7: latched edge event survives until a clear
  p_edge_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !level_i && !clr_i) |=> pend_o);

  // R8: level mode tracks the qualified input one cycle later
  p_level_track_r8: assert property (@(posedge clk) disable iff (rst)
    level_i |=> (pend_o == $past(qual)));

  // R4: a clear with no new event drops an edge-mode pending bit
  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !level_i && !hit) |=> !pend_o);
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
  parameter int N_SRC   = 16,
  parameter int LINE_W  = 3,
  parameter int LINE_ID = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0]              pend_i,
  input  logic [N_SRC-1:0]              en_i,
  input  logic [N_SRC-1:0][LINE_W-1:0]  route_i,
  input  logic                          oe_i,
  output logic [N_SRC-1:0]              status_o,
  output logic                          line_o
);
  localparam logic [LINE_W-1:0] MY_ID = LINE_W'(LINE_ID);

  logic line_q;

  always_comb begin
    for (int n = 0; n < N_SRC; n++) begin
      status_o[n] = pend_i[n] & en_i[n] & (route_i[n] == MY_ID);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= (|status_o) & oe_i;
  end

  assign line_o = line_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int N_SRC  = DEF_SRC,
  parameter int N_LINE = DEF_LINE,
  parameter int LINE_W = 3,
  parameter int AW     = DEF_AW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [AW-1:0]                 bus_addr,
  input  logic                          bus_wr,
  input  logic [BUS_W-1:0]              bus_wdata,
  output logic [BUS_W-1:0]              bus_rdata,
  input  logic [N_LINE-1:0][N_SRC-1:0]  status_i,
  output logic [N_SRC-1:0][LINE_W-1:0]  route_o,
  output logic [N_SRC-1:0]              en_o,
  output logic [N_LINE-1:0]             oe_o,
  output logic [N_SRC-1:0]              act_low_o,
  output logic [N_SRC-1:0]              level_o,
  output logic [N_SRC-1:0]              clr_o
);
  localparam int PER_WORD = BUS_W / NIB_W;
  localparam int RT_WORDS = (N_SRC + PER_WORD - 1) / PER_WORD;
  localparam int ST_WORDS = (N_LINE + 1) / 2;
  localparam int IDX_ST   = RT_WORDS;
  localparam int IDX_OE   = IDX_ST + ST_WORDS;
  localparam int IDX_CLR  = IDX_OE + 1;
  localparam int IDX_SNS  = IDX_CLR + 1;

  logic [RT_WORDS-1:0][BUS_W-1:0] rt_q;
  logic [N_LINE-1:0]              oe_q;
  logic [2*N_SRC-1:0]             sns_q;
  logic [BUS_W-1:0]               rd_d, rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_q  <= '0;
      oe_q  <= '0;
      sns_q <= '0;
    end else if (bus_wr) begin
      for (int w = 0; w < RT_WORDS; w++) begin
        if (bus_addr == AW'(w)) rt_q[w] <= bus_wdata;
      end
      if (bus_addr == AW'(IDX_OE))  oe_q  <= bus_wdata[HALF_W +: N_LINE];
      if (bus_addr == AW'(IDX_SNS)) sns_q <= bus_wdata[2*N_SRC-1:0];
    end
  end

  generate
    for (genvar n = 0; n < N_SRC; n++) begin : g_src_fields
      assign route_o[n]   = rt_q[n / PER_WORD][(n % PER_WORD)*NIB_W +: LINE_W];
      assign en_o[n]      = rt_q[n / PER_WORD][(n % PER_WORD)*NIB_W + NIB_W - 1];
      assign act_low_o[n] = sns_q[2*n];
      assign level_o[n]   = sns_q[2*n+1];
    end
  endgenerate

  assign oe_o  = oe_q;
  assign clr_o = (bus_wr && bus_addr == AW'(IDX_CLR)) ? bus_wdata[N_SRC-1:0] : '0;

  always_comb begin
    rd_d = '0;
    for (int w = 0; w < RT_WORDS; w++) begin
      if (bus_addr == AW'(w)) rd_d = rt_q[w];
    end
    for (int s = 0; s < ST_WORDS; s++) begin
      if (bus_addr == AW'(IDX_ST + s)) begin
        rd_d[N_SRC-1:0]          = status_i[2*s];
        rd_d[HALF_W +: N_SRC]    = status_i[2*s+1];
      end
    end
    if (bus_addr == AW'(IDX_OE))  rd_d[HALF_W +: N_LINE] = oe_q;
    if (bus_addr == AW'(IDX_SNS)) rd_d[2*N_SRC-1:0]      = sns_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;

  // R4: the clear word produces no strobe outside a write to it
  p_clr_only_on_write_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |-> (clr_o == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_SRC  = DEF_SRC,
  parameter int N_LINE = DEF_LINE,
  parameter int AW     = DEF_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  src_i,
  output logic [N_LINE-1:0] irq_line_o
);
  localparam int LINE_W = (N_LINE > 1) ? $clog2(N_LINE) : 1;

  logic [N_SRC-1:0][LINE_W-1:0] route;
  logic [N_SRC-1:0]             en, act_low, level, clr, pend;
  logic [N_LINE-1:0]            oe;
  logic [N_LINE-1:0][N_SRC-1:0] status;

  irq_regfile #(
    .N_SRC(N_SRC), .N_LINE(N_LINE), .LINE_W(LINE_W), .AW(AW)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .status_i(status),
    .route_o(route), .en_o(en), .oe_o(oe),
    .act_low_o(act_low), .level_o(level), .clr_o(clr)
  );

  generate
    for (genvar n = 0; n < N_SRC; n++) begin : g_sense
      irq_src_sense u_sense (
        .clk(clk), .rst(rst),
        .raw_i(src_i[n]), .act_low_i(act_low[n]), .level_i(level[n]),
        .clr_i(clr[n]), .pend_o(pend[n])
      );
    end
    for (genvar k = 0; k < N_LINE; k++) begin : g_line
      irq_line_merge #(
        .N_SRC(N_SRC), .LINE_W(LINE_W), .LINE_ID(k)
      ) u_merge (
        .clk(clk), .rst(rst),
        .pend_i(pend), .en_i(en), .route_i(route), .oe_i(oe[k]),
        .status_o(status[k]), .line_o(irq_line_o[k])
      );
    end
  endgenerate

  // R1: outputs come out of reset low
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_line_o == '0));

  // R5: a line whose enable was off in the previous cycle stays low
  p_line_gated_r5: assert property (@(posedge clk) disable iff (rst)
    ((irq_line_o & ~$past(oe)) == '0));
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] src = '0;
  logic [7:0]  irq_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_i(src), .irq_line_o(irq_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_addr = idx; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_addr = idx;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic set_src(input int n, input logic v);
    @(negedge clk);
    src[n] = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 lines", {24'h0, irq_line}, 32'h0);
    rd_reg(4'd0, d); chk("R1 route0", d, 32'h0);
    rd_reg(4'd1, d); chk("R1 route1", d, 32'h0);
    rd_reg(4'd6, d); chk("R1 oe", d, 32'h0);
    rd_reg(4'd8, d); chk("R1 sense", d, 32'h0);
  endtask

  task automatic t_route_latency;
    logic [31:0] d;
    wr_reg(4'd6, 32'h00FF_0000);
    rd_reg(4'd6, d); chk("R5 oe readback", d, 32'h00FF_0000);
    wr_reg(4'd0, 32'h0000_D000);          // src3 -> line5, enabled
    set_src(3, 1'b1);
    tick(3); chk("R9 not before 4th edge", {24'h0, irq_line}, 32'h0);
    tick(1); chk("R9 R2 line5 on 4th edge", {24'h0, irq_line}, 32'h20);
    rd_reg(4'd4, d); chk("R3 status odd line upper half", d, 32'h0008_0000);
  endtask

  task automatic t_edge_hold;
    set_src(3, 1'b0);
    tick(6); chk("R7 edge pending held", {24'h0, irq_line}, 32'h20);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr_reg(4'd7, 32'h0000_FFF7);
    tick(3); chk("R4 zero bit keeps pending", {24'h0, irq_line}, 32'h20);
    wr_reg(4'd7, 32'h0000_0008);
    tick(2); chk("R4 one bit clears", {24'h0, irq_line}, 32'h0);
    rd_reg(4'd4, d); chk("R4 status cleared", d, 32'h0);
    rd_reg(4'd7, d); chk("R4 clear word reads 0", d, 32'h0);
  endtask

  task automatic t_oe_gate;
    logic [31:0] d;
    wr_reg(4'd6, 32'h00DF_0000);          // line5 output disabled
    set_src(3, 1'b1); tick(3); set_src(3, 1'b0); tick(5);
    chk("R5 gated line low", {24'h0, irq_line}, 32'h0);
    rd_reg(4'd4, d); chk("R5 status still set", d, 32'h0008_0000);
    wr_reg(4'd6, 32'h00FF_0000);
    tick(2); chk("R5 line after enable", {24'h0, irq_line}, 32'h20);
    wr_reg(4'd7, 32'h0000_0008); tick(2);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr_reg(4'd1, 32'h0000_0010);          // src9 -> line1, not enabled
    set_src(9, 1'b1); tick(3); set_src(9, 1'b0); tick(5);
    rd_reg(4'd2, d); chk("R2 disabled hidden in status", d, 32'h0);
    chk("R2 disabled line low", {24'h0, irq_line}, 32'h0);
    wr_reg(4'd1, 32'h0000_0090);
    tick(2); chk("R2 pending kept under mask", {24'h0, irq_line}, 32'h02);
    rd_reg(4'd2, d); chk("R3 status line1", d, 32'h0200_0000);
    wr_reg(4'd7, 32'h0000_0200); tick(2);
    chk("R4 clear src9", {24'h0, irq_line}, 32'h0);
  endtask

  task automatic t_level_low;
    logic [31:0] d;
    wr_reg(4'd8, 32'h0300_0000);          // src12 level, active-low
    rd_reg(4'd8, d); chk("R6 sense readback", d, 32'h0300_0000);
    wr_reg(4'd1, 32'h000A_0000);          // src12 -> line2, enabled
    tick(3); chk("R8 active-low level asserted", {24'h0, irq_line}, 32'h04);
    wr_reg(4'd7, 32'h0000_1000);
    tick(3); chk("R8 clear has no lasting effect", {24'h0, irq_line}, 32'h04);
    set_src(12, 1'b1);
    tick(3); chk("R9 fall not before 4th edge", {24'h0, irq_line}, 32'h04);
    tick(1); chk("R8 R9 level released", {24'h0, irq_line}, 32'h0);
  endtask

  task automatic t_level_high;
    wr_reg(4'd8, 32'h0300_0002);          // src0 level, active-high
    wr_reg(4'd0, 32'h0000_D008);          // src0 -> line0
    set_src(0, 1'b1);
    tick(5); chk("R8 active-high level on", {24'h0, irq_line}, 32'h01);
    set_src(0, 1'b0);
    tick(5); chk("R8 active-high level off", {24'h0, irq_line}, 32'h0);
  endtask

  task automatic t_edge_low;
    logic [31:0] d;
    wr_reg(4'd8, 32'h0300_4002);          // src7 edge, active-low
    wr_reg(4'd0, 32'hE000_D008);          // src7 -> line6
    tick(5); chk("R7 polarity change no event", {24'h0, irq_line}, 32'h0);
    set_src(7, 1'b1);
    tick(5); chk("R7 inactive edge ignored", {24'h0, irq_line}, 32'h0);
    set_src(7, 1'b0);
    tick(5); chk("R7 falling edge latched", {24'h0, irq_line}, 32'h40);
    set_src(7, 1'b1);
    tick(5); chk("R7 held after release", {24'h0, irq_line}, 32'h40);
    rd_reg(4'd5, d); chk("R3 status line6 lower half", d, 32'h0000_0080);
    wr_reg(4'd7, 32'h0000_0080); tick(2);
  endtask

  task automatic t_route_off;
    logic [31:0] d;
    set_src(3, 1'b1); tick(3); set_src(3, 1'b0);
    set_src(12, 1'b0);
    tick(6); chk("R10 precondition", {24'h0, irq_line}, 32'h24);
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd1, 32'h0);
    tick(2); chk("R10 lines low", {24'h0, irq_line}, 32'h0);
    for (int i = 2; i < 6; i++) begin
      rd_reg(4'(i), d); chk("R10 status empty", d, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_route_latency();
    t_edge_hold();
    t_w1c();
    t_oe_gate();
    t_disabled();
    t_level_low();
    t_level_high();
    t_edge_low();
    t_route_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule